// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block is a debug-support comparator that watches two buses at once. The first is the CPU's own local bus, which carries logical addresses. The second is a shared bus that every master on the chip can drive, and it carries physical addresses. Two programmable channels, A and B, each compare an address under a mask and check a set of cycle qualifiers. Channel B also compares the bus data under a data mask. When either channel matches, the block raises one break request toward the CPU. It also records, separately for each channel and each bus, that a match occurred.

Software programs the channels through a plain register port and reads back the settings and the sticky match flags. A flag, once set, stays set until software writes 0 to it. While any flag is set, the block raises no new break request. The shared-bus side turns each issued address into the physical address the bus really carries before comparing it. Both bus inputs only observe traffic. They have a valid strobe and no ready, so the block never applies back-pressure, and a cycle is sampled in every clock where its valid is high.

Top module: `brk_cmp_top`

## Requirements
- R1: A channel's address matches when every bit whose mask bit is 0 equals the programmed address. Mask bits at 1 are ignored.
- R2: Channel B also needs the bus data to equal its data register on every bit whose data-mask bit is 0. Channel A ignores the data.
- R3: The qualifier register holds three 2-bit groups. Bits [1:0] select the bus: bit0 is local, bit1 is shared. Bits [3:2] select the cycle type: bit2 is instruction fetch, bit3 is data access. Bits [5:4] select the direction: bit4 is read, bit5 is write. A cycle qualifies only if it is enabled in every group, so a channel with any group at 00 never matches.
- R4: The flag register (address 8) holds sticky flags. Bit0 is A on the local bus, bit1 is A on the shared bus, bit2 is B on the local bus and bit3 is B on the shared bus. Hardware only sets them. They stay set over later idle cycles.
- R5: A write to the flag register ANDs the flags with the written value. A 0 clears a flag and a 1 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R6: `brk_req` is a registered pulse, high for exactly one cycle. It appears in the cycle after a matching bus cycle when all flags were clear. It is suppressed while any flag is set. Matches on both channels in the same cycle give one pulse but set both flags.
- R7: On the shared bus, an address whose top three bits are not 3'b111 is compared with those bits forced to 0. An address with top bits 3'b111 is compared unchanged.
- R8: A shared-bus instruction fetch is compared with its address rounded down to a 4-byte boundary. Shared-bus data accesses and all local-bus cycles are compared with their low bits as issued.
- R9: The register map is: 0 = A address, 1 = A mask, 2 = A qualifier, 3 = B address, 4 = B mask, 5 = B qualifier, 6 = B data, 7 = B data mask, 8 = flags. Every register reads back what was written, and all reset to 0.
- R10: A register written in cycle N governs compares from cycle N+1. A bus cycle in cycle N is compared against the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| lb_valid | input | 1 | Local-bus cycle present |
| lb_addr | input | 32 | Local-bus logical address |
| lb_data | input | 32 | Local-bus data |
| lb_fetch | input | 1 | Local-bus cycle is an instruction fetch (0 = data access) |
| lb_write | input | 1 | Local-bus cycle is a write (0 = read) |
| sb_valid | input | 1 | Shared-bus cycle present, from any master |
| sb_addr | input | 32 | Address as issued by the master, before translation |
| sb_data | input | 32 | Shared-bus data |
| sb_fetch | input | 1 | Shared-bus cycle is an instruction fetch |
| sb_write | input | 1 | Shared-bus cycle is a write |
| brk_req | output | 1 | One-cycle break request to the CPU |

## Verification
The bench goes after the address translation corners: one address in the reserved top region, which must pass unchanged, and addresses in the lower regions, which must compare cleared. A design that cleared the top bits everywhere, or nowhere, would report a false match or miss a real one. It also drives a misaligned shared-bus fetch next to a misaligned data access at the same address. Rounding both, or neither, flips one of the two expected flags. Further cases are a hit in both channels in one cycle, which must give a single pulse and two flags; a partial write-0, after which the remaining flag must still block requests; a qualifier with a 00 group; and a bus cycle in the same cycle as an address rewrite, which a design that compared against the incoming value would wrongly hit.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int QW    = 6;
  localparam int NCH   = 2;
  localparam int NBUS  = 2;
  localparam int NFLAG = NCH * NBUS;
  localparam int RAW   = 4;
  localparam int REGS_PER_CH = 3;

  localparam logic [RAW-1:0] RG_B_DATA  = 4'd6;
  localparam logic [RAW-1:0] RG_B_DMASK = 4'd7;
  localparam logic [RAW-1:0] RG_FLAGS   = 4'd8;

  // qualifier groups: [1:0] bus {shared,local}, [3:2] {data,fetch}, [5:4] {write,read}
  function automatic logic qual_ok(input logic [QW-1:0] q, input logic on_shared,
                                   input logic fetch, input logic write);
    logic bus_ok, cyc_ok, dir_ok;
    bus_ok = on_shared ? q[1] : q[0];
    cyc_ok = fetch ? q[2] : q[3];
    dir_ok = write ? q[5] : q[4];
    return bus_ok & cyc_ok & dir_ok;
  endfunction

  function automatic logic qual_armed(input logic [QW-1:0] q);
    return (q[1:0] != 2'b00) && (q[3:2] != 2'b00) && (q[5:4] != 2'b00);
  endfunction
endpackage

// File: rtl/brk_xlate.sv
module brk_xlate #(
  parameter int AW       = 32,
  parameter int RB       = 3,
  parameter int ALIGN_LG = 2
) (
  input  logic [AW-1:0] issued_addr,
  input  logic          fetch,
  output logic [AW-1:0] phys_addr
);
  localparam logic [RB-1:0] RESERVED_TOP = '1;

  always_comb begin
    phys_addr = issued_addr;
    if (issued_addr[AW-1 -: RB] != RESERVED_TOP)
      phys_addr[AW-1 -: RB] = '0;
    if (fetch)
      phys_addr[ALIGN_LG-1:0] = '0;
  end
endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter bit ON_SHARED = 1'b0
) (
  input  logic          cyc_valid,
  input  logic [AW-1:0] cyc_addr,
  input  logic [DW-1:0] cyc_data,
  input  logic          cyc_fetch,
  input  logic          cyc_write,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] ref_amask,
  input  logic [DW-1:0] ref_data,
  input  logic [DW-1:0] ref_dmask,
  input  logic [QW-1:0] ref_qual,
  output logic          hit
);
  logic addr_eq, data_eq, kind_ok;

  always_comb begin
    addr_eq = ((cyc_addr ^ ref_addr) & ~ref_amask) == '0;
    data_eq = ((cyc_data ^ ref_data) & ~ref_dmask) == '0;
    kind_ok = qual_ok(ref_qual, ON_SHARED, cyc_fetch, cyc_write);
    hit     = cyc_valid & kind_ok & addr_eq & data_eq;
  end
endmodule

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wr,
  input  logic [RAW-1:0]            cfg_addr,
  input  logic [AW-1:0]             cfg_wdata,
  input  logic [NFLAG-1:0]          hit_set,
  output logic [NCH-1:0][AW-1:0]    ch_addr,
  output logic [NCH-1:0][AW-1:0]    ch_amask,
  output logic [NCH-1:0][QW-1:0]    ch_qual,
  output logic [DW-1:0]             b_data,
  output logic [DW-1:0]             b_dmask,
  output logic [NFLAG-1:0]          flags,
  output logic [AW-1:0]             cfg_rdata
);
  logic [NFLAG-1:0] flags_kept;

  always_comb begin
    flags_kept = flags;
    if (cfg_wr && cfg_addr == RG_FLAGS)
      flags_kept = flags & cfg_wdata[NFLAG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_addr  <= '0;
      ch_amask <= '0;
      ch_qual  <= '0;
      b_data   <= '0;
      b_dmask  <= '0;
      flags    <= '0;
    end else begin
      flags <= flags_kept | hit_set;
      if (cfg_wr) begin
        for (int c = 0; c < NCH; c++) begin
          if (cfg_addr == RAW'(REGS_PER_CH * c))     ch_addr[c]  <= cfg_wdata;
          if (cfg_addr == RAW'(REGS_PER_CH * c + 1)) ch_amask[c] <= cfg_wdata;
          if (cfg_addr == RAW'(REGS_PER_CH * c + 2)) ch_qual[c]  <= cfg_wdata[QW-1:0];
        end
        if (cfg_addr == RG_B_DATA)  b_data  <= cfg_wdata[DW-1:0];
        if (cfg_addr == RG_B_DMASK) b_dmask <= cfg_wdata[DW-1:0];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (cfg_addr == RAW'(REGS_PER_CH * c))     cfg_rdata = ch_addr[c];
      if (cfg_addr == RAW'(REGS_PER_CH * c + 1)) cfg_rdata = ch_amask[c];
      if (cfg_addr == RAW'(REGS_PER_CH * c + 2)) cfg_rdata = AW'(ch_qual[c]);
    end
    if (cfg_addr == RG_B_DATA)  cfg_rdata = AW'(b_data);
    if (cfg_addr == RG_B_DMASK) cfg_rdata = AW'(b_dmask);
    if (cfg_addr == RG_FLAGS)   cfg_rdata = AW'(flags);
  end
endmodule

// File: rtl/brk_cmp_top.sv
module brk_cmp_top
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [3:0]     cfg_addr,
  input  logic [AW-1:0]  cfg_wdata,
  output logic [AW-1:0]  cfg_rdata,
  input  logic           lb_valid,
  input  logic [AW-1:0]  lb_addr,
  input  logic [DW-1:0]  lb_data,
  input  logic           lb_fetch,
  input  logic           lb_write,
  input  logic           sb_valid,
  input  logic [AW-1:0]  sb_addr,
  input  logic [DW-1:0]  sb_data,
  input  logic           sb_fetch,
  input  logic           sb_write,
  output logic           brk_req
);
  logic [NCH-1:0][AW-1:0] ch_addr;
  logic [NCH-1:0][AW-1:0] ch_amask;
  logic [NCH-1:0][QW-1:0] ch_qual;
  logic [DW-1:0]          b_data;
  logic [DW-1:0]          b_dmask;
  logic [NFLAG-1:0]       flags;
  logic [NFLAG-1:0]       hit;
  logic [AW-1:0]          sb_phys;
  logic                   req_q;

  brk_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hit_set(hit),
    .ch_addr(ch_addr), .ch_amask(ch_amask), .ch_qual(ch_qual),
    .b_data(b_data), .b_dmask(b_dmask),
    .flags(flags), .cfg_rdata(cfg_rdata)
  );

  brk_xlate #(.AW(AW)) u_xlate (
    .issued_addr(sb_addr), .fetch(sb_fetch), .phys_addr(sb_phys)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] dmask_c;
    if (c == NCH - 1) begin : g_data
      assign dmask_c = b_dmask;
    end else begin : g_nodata
      assign dmask_c = '1;
    end
    for (genvar b = 0; b < NBUS; b++) begin : g_bus
      logic          v;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic          f, w;
      if (b == 0) begin : g_local
        assign {v, a, d, f, w} = {lb_valid, lb_addr, lb_data, lb_fetch, lb_write};
      end else begin : g_shared
        assign {v, a, d, f, w} = {sb_valid, sb_phys, sb_data, sb_fetch, sb_write};
      end
      brk_match #(.AW(AW), .DW(DW), .ON_SHARED(b == 1)) u_match (
        .cyc_valid(v), .cyc_addr(a), .cyc_data(d), .cyc_fetch(f), .cyc_write(w),
        .ref_addr(ch_addr[c]), .ref_amask(ch_amask[c]),
        .ref_data(b_data), .ref_dmask(dmask_c), .ref_qual(ch_qual[c]),
        .hit(hit[c * NBUS + b])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= (|hit) & ~(|flags);
  end

  assign brk_req = req_q;
endmodule

// File: rtl/brk_cmp_chk.sv
module brk_cmp_chk
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_wr,
  input logic [RAW-1:0]         cfg_addr,
  input logic                   brk_req,
  input logic [NFLAG-1:0]       flags,
  input logic [NCH-1:0][QW-1:0] ch_qual,
  input logic                   sb_valid,
  input logic [AW-1:0]          sb_addr,
  input logic                   sb_fetch,
  input logic [AW-1:0]          sb_phys
);
  p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);

  p_req_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (flags != '0));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_addr == RG_FLAGS) |=> ((flags & $past(flags)) == $past(flags)));

  p_qual_off_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual_armed(ch_qual[0]) && flags[1:0] == 2'b00) |=> (flags[1:0] == 2'b00));

  p_qual_off_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual_armed(ch_qual[1]) && flags[3:2] == 2'b00) |=> (flags[3:2] == 2'b00));

  p_xlate_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_valid && sb_addr[AW-1 -: 3] != 3'b111) |-> (sb_phys[AW-1 -: 3] == 3'b000));

  p_fetch_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_valid && sb_fetch) |-> (sb_phys[1:0] == 2'b00));
endmodule

bind brk_cmp_top brk_cmp_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .brk_req(brk_req), .flags(flags), .ch_qual(ch_qual),
  .sb_valid(sb_valid), .sb_addr(sb_addr), .sb_fetch(sb_fetch), .sb_phys(sb_phys)
);

// File: tb/brk_cmp_top_tb.sv
`timescale 1ns/1ps
module brk_cmp_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = 4'd8;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lb_valid = 1'b0, lb_fetch = 1'b0, lb_write = 1'b0;
  logic [31:0] lb_addr = '0, lb_data = '0;
  logic        sb_valid = 1'b0, sb_fetch = 1'b0, sb_write = 1'b0;
  logic [31:0] sb_addr = '0, sb_data = '0;
  logic        brk_req;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  brk_cmp_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lb_valid(lb_valid), .lb_addr(lb_addr), .lb_data(lb_data),
    .lb_fetch(lb_fetch), .lb_write(lb_write),
    .sb_valid(sb_valid), .sb_addr(sb_addr), .sb_data(sb_data),
    .sb_fetch(sb_fetch), .sb_write(sb_write), .brk_req(brk_req)
  );

  typedef struct packed {
    logic        shr;
    logic [31:0] addr;
    logic [31:0] data;
    logic        fetch;
    logic        wr;
    logic [3:0]  exp;
  } vec_t;

  // A: addr 0x1000 mask 0xF, qual 0x2B (either bus, data, write)
  // B: addr 0x0C002000, data 0xAB under mask 0xFFFFFF00, qual 0x3E (shared, any cycle, any dir)
  localparam vec_t VECS [13] = '{
    '{1'b0, 32'h0000_1004, 32'h0,         1'b0, 1'b1, 4'b0001},  // R1 masked low nibble
    '{1'b0, 32'h0000_1004, 32'h0,         1'b0, 1'b0, 4'b0000},  // R3 read not enabled
    '{1'b0, 32'h0000_1010, 32'h0,         1'b0, 1'b1, 4'b0000},  // R1 unmasked bit differs
    '{1'b0, 32'h0000_1008, 32'h0,         1'b1, 1'b1, 4'b0000},  // R3 fetch not enabled
    '{1'b1, 32'hA000_100C, 32'h0,         1'b0, 1'b1, 4'b0010},  // R7 top bits cleared
    '{1'b1, 32'hE000_1000, 32'h0,         1'b0, 1'b1, 4'b0000},  // R7 reserved region kept
    '{1'b1, 32'h0C00_2000, 32'h1234_56AB, 1'b0, 1'b0, 4'b1000},  // R2 data masked match
    '{1'b1, 32'h0C00_2000, 32'h0000_00AC, 1'b0, 1'b0, 4'b0000},  // R2 data mismatch
    '{1'b0, 32'h0C00_2000, 32'h0000_00AB, 1'b0, 1'b0, 4'b0000},  // R3 B local disabled
    '{1'b1, 32'h8C00_2002, 32'h0000_00AB, 1'b1, 1'b0, 4'b1000},  // R8 fetch rounded
    '{1'b1, 32'h0C00_2002, 32'h0000_00AB, 1'b0, 1'b0, 4'b0000},  // R8 data not rounded
    '{1'b1, 32'h0000_1000, 32'h0000_00AB, 1'b0, 1'b1, 4'b0010},  // R2 A ignores data
    '{1'b1, 32'hC000_1000, 32'h0,         1'b0, 1'b1, 4'b0010}   // R7 region 110 cleared
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_addr = 4'd8;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
    cfg_addr = 4'd8;
    #1;
  endtask

  task automatic set_bus(input logic shr, input logic [31:0] a, input logic [31:0] d,
                         input logic f, input logic w);
    if (shr) begin
      sb_valid = 1'b1; sb_addr = a; sb_data = d; sb_fetch = f; sb_write = w;
    end else begin
      lb_valid = 1'b1; lb_addr = a; lb_data = d; lb_fetch = f; lb_write = w;
    end
  endtask

  task automatic bus_cyc(input logic shr, input logic [31:0] a, input logic [31:0] d,
                         input logic f, input logic w);
    @(negedge clk);
    set_bus(shr, a, d, f, w);
    @(negedge clk);
    lb_valid = 1'b0; sb_valid = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R9, R6)
    chk("R6 reset req", {31'b0, brk_req}, 32'h0);
    rd_reg(4'd8, rv); chk("R9 reset flags", rv, 32'h0);
    rd_reg(4'd0, rv); chk("R9 reset A addr", rv, 32'h0);

    wr_reg(4'd0, 32'h0000_1000);
    wr_reg(4'd1, 32'h0000_000F);
    wr_reg(4'd2, 32'h0000_002B);
    wr_reg(4'd3, 32'h0C00_2000);
    wr_reg(4'd4, 32'h0000_0000);
    wr_reg(4'd6, 32'h0000_00AB);
    wr_reg(4'd7, 32'hFFFF_FF00);
    wr_reg(4'd5, 32'h0000_003E);
    rd_reg(4'd1, rv); chk("R9 readback A mask", rv, 32'h0000_000F);
    rd_reg(4'd5, rv); chk("R9 readback B qual", rv, 32'h0000_003E);
    rd_reg(4'd7, rv); chk("R9 readback B dmask", rv, 32'hFFFF_FF00);

    // table walk
    foreach (VECS[i]) begin
      wr_reg(4'd8, 32'h0);
      bus_cyc(VECS[i].shr, VECS[i].addr, VECS[i].data, VECS[i].fetch, VECS[i].wr);
      chk($sformatf("R6 vec%0d req", i), {31'b0, brk_req}, {31'b0, VECS[i].exp != 4'b0});
      rd_reg(4'd8, rv);
      chk($sformatf("R4 vec%0d flags", i), rv, {28'b0, VECS[i].exp});
    end

    // both channels in one cycle: one pulse, two flags (R6)
    wr_reg(4'd8, 32'h0);
    @(negedge clk);
    set_bus(1'b0, 32'h0000_1000, 32'h0, 1'b0, 1'b1);
    set_bus(1'b1, 32'h0C00_2000, 32'h0000_00AB, 1'b0, 1'b0);
    @(negedge clk);
    lb_valid = 1'b0; sb_valid = 1'b0;
    chk("R6 dual hit req", {31'b0, brk_req}, 32'h1);
    rd_reg(4'd8, rv); chk("R6 dual hit flags", rv, 32'h9);
    @(negedge clk);
    chk("R6 single pulse", {31'b0, brk_req}, 32'h0);
    repeat (3) @(negedge clk);
    rd_reg(4'd8, rv); chk("R4 flags sticky", rv, 32'h9);

    // new hit while flags set: no request
    bus_cyc(1'b0, 32'h0000_1000, 32'h0, 1'b0, 1'b1);
    chk("R6 blocked by flags", {31'b0, brk_req}, 32'h0);

    // partial write-0 (R5)
    wr_reg(4'd8, 32'h0000_0008);
    rd_reg(4'd8, rv); chk("R5 partial clear", rv, 32'h8);
    bus_cyc(1'b0, 32'h0000_1000, 32'h0, 1'b0, 1'b1);
    chk("R6 blocked by remaining flag", {31'b0, brk_req}, 32'h0);
    rd_reg(4'd8, rv); chk("R4 flag set again", rv, 32'h9);
    wr_reg(4'd8, 32'h0);
    rd_reg(4'd8, rv); chk("R5 full clear", rv, 32'h0);
    bus_cyc(1'b0, 32'h0000_1000, 32'h0, 1'b0, 1'b1);
    chk("R6 rearmed after clear", {31'b0, brk_req}, 32'h1);

    // zero qualifier group (R3)
    wr_reg(4'd2, 32'h0000_0028);
    wr_reg(4'd8, 32'h0);
    bus_cyc(1'b0, 32'h0000_1000, 32'h0, 1'b0, 1'b1);
    chk("R3 zero group req", {31'b0, brk_req}, 32'h0);
    rd_reg(4'd8, rv); chk("R3 zero group flags", rv, 32'h0);
    wr_reg(4'd2, 32'h0000_002B);

    // setting takes effect next cycle (R10)
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 4'd0; cfg_wdata = 32'h0000_3000;
    set_bus(1'b0, 32'h0000_3000, 32'h0, 1'b0, 1'b1);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_addr = 4'd8; lb_valid = 1'b0;
    chk("R10 old value used", {31'b0, brk_req}, 32'h0);
    rd_reg(4'd8, rv); chk("R10 no flag on old value", rv, 32'h0);
    bus_cyc(1'b0, 32'h0000_3000, 32'h0, 1'b0, 1'b1);
    chk("R10 new value used", {31'b0, brk_req}, 32'h1);
    rd_reg(4'd8, rv); chk("R1 new address flag", rv, 32'h1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule